// File: doc/BRIEF.md
# Configurable UART Receive Framer

This block turns an asynchronous serial input into characters. It sits behind an external synchroniser and an external baud generator. The generator supplies a single-cycle tick at `OVERSAMPLE` times the bit rate. An 8-bit format word selects three things: a character length of 6, 7 or 8 bits; a parity mode of even, odd, space, mark or none; and a stop-bit count of one or two. Each completed character appears for one clock on `char_valid`, together with its data and a parity-error flag and a framing-error flag. A line held low (a break) is reported as a single character with data 0x00 and a framing error. No further character is accepted until the line has been seen high again.

The control is a state machine with six states. IDLE waits for an armed falling edge. START confirms the start bit at mid-bit. DATA shifts in the data bits. PARITY checks the parity bit. STOP1 and STOP2 sample the stop bits. The transitions are as follows:
- IDLE→START when the line is seen low on a tick after it was seen high (start detect).
- START→DATA when the mid-bit sample is low (start confirmed).
- START→IDLE when the mid-bit sample is high (glitch reject).
- DATA→PARITY after the last data bit if parity is enabled.
- DATA→STOP1 after the last data bit if parity is off.
- PARITY→STOP1 after the parity sample.
- STOP1→STOP2 when two stop bits are selected.
- STOP1→IDLE or STOP2→IDLE on the final stop sample (character emit).
- Any state→IDLE when the receiver is off or a receiver reset is pending (abort).

Reception is gated by two pulse inputs: one switches the receiver on and one switches it off. A reset request clears the framer through a one-cycle internal pending flag, which clears itself.

Top module: `uart_rx_framer`

## Requirements
- R1: Format bits [2:1] set the character length: 11 gives 6 bits, 10 gives 7 bits, and any other pattern gives 8 bits. Data arrive least-significant bit first, and `char_data` bits at and above the length read 0.
- R2: Format bits [5:3] = 000 select even parity and 001 select odd parity. `parity_err` is 1 when the received parity bit makes the total count of ones (data plus parity) odd for even parity, or even for odd parity.
- R3: Format bits [5:3] = 010 (space) require the parity bit to be 0, and 011 (mark) require it to be 1. Any other value raises `parity_err`.
- R4: When format bit 5 is 1, no parity bit is expected, `parity_err` stays 0, and the bit after the data is taken as the first stop bit.
- R5: Format bits [7:6] = 10 select two stop bits and any other pattern selects one. `framing_err` is 1 if any stop sample is low.
- R6: An all-zero character with a low stop sample is reported once, with data 0x00 and `framing_err` = 1. No further character starts until the line has been sampled high on a tick.
- R7: A start bit is accepted only if the line is still low at the mid-bit sample, `OVERSAMPLE/2` ticks after detection. Otherwise the framer returns to IDLE and emits nothing.
- R8: The receiver is off after `rst_n`. `rx_enable` switches it on and `rx_disable` switches it off, and off wins when both are high. While off, no character is emitted and a character in progress is dropped.
- R9: A pulse on `rx_reset_req` returns the framer to IDLE one cycle later and discards a partial character. The internal request clears itself, and the next character is received normally.
- R10: The format word is captured only while IDLE. A change during a character does not affect that character.
- R11: `char_valid` is a one-cycle pulse. The two error flags are high only together with it, and after `rst_n` all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| rx_line | input | 1 | Synchronised serial input, idle high |
| mode | input | 8 | Format word (length [2:1], parity [5:3], stop [7:6]; bit 0 unused) |
| rx_enable | input | 1 | Pulse: switch receiver on |
| rx_disable | input | 1 | Pulse: switch receiver off (wins) |
| rx_reset_req | input | 1 | Pulse: clear framer state |
| char_data | output | 8 | Received character, zero-extended |
| char_valid | output | 1 | One-cycle strobe for a completed character |
| parity_err | output | 1 | Parity mismatch for the strobed character |
| framing_err | output | 1 | Low stop sample for the strobed character |

## Verification
The embedded properties assume that `baud_tick` never comes on consecutive clocks more often than the mid-bit spacing allows. They also assume that `rx_line` changes only at bit boundaries that are many ticks apart, and that the stop field uses only 00 or 10. The bench ticks every second clock and drives each bit for exactly `OVERSAMPLE` ticks, so every sample lands well inside its bit. The bench draws formats only from the defined stop codes, and it changes the format word mid-character only in the directed case that tests R10.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int unsigned MAX_DATA_BITS = 8;
    localparam int unsigned LEN_W         = $clog2(MAX_DATA_BITS + 1);
    localparam int unsigned IDX_W         = $clog2(MAX_DATA_BITS);
    localparam int unsigned FMT_W         = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2
    } rx_state_t;

    typedef enum logic [2:0] {
        PAR_EVEN, PAR_ODD, PAR_SPACE, PAR_MARK, PAR_NONE
    } par_kind_t;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        par_kind_t        par;
        logic             two_stop;
    } rx_cfg_t;

    function automatic logic par_expected(par_kind_t k, logic ones_odd);
        case (k)
            PAR_EVEN:  return ones_odd;
            PAR_ODD:   return ~ones_odd;
            PAR_SPACE: return 1'b0;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/uart_rx_mode_decode.sv
module uart_rx_mode_decode
    import uart_rx_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output rx_cfg_t          cfg
);
    logic fmt_unused;
    assign fmt_unused = fmt[0];

    always_comb begin
        case (fmt[2:1])
            2'b11:   cfg.nbits = LEN_W'(6);
            2'b10:   cfg.nbits = LEN_W'(7);
            default: cfg.nbits = LEN_W'(8);
        endcase
        if (fmt[5]) begin
            cfg.par = PAR_NONE;
        end else begin
            case (fmt[4:3])
                2'b00:   cfg.par = PAR_EVEN;
                2'b01:   cfg.par = PAR_ODD;
                2'b10:   cfg.par = PAR_SPACE;
                default: cfg.par = PAR_MARK;
            endcase
        end
        cfg.two_stop = (fmt[7:6] == 2'b10);
    end
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic half_sel,
    output logic sample
);
    localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
    localparam int unsigned HALF  = OVERSAMPLE / 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit  = half_sel ? CNT_W'(HALF - 1) : CNT_W'(OVERSAMPLE - 1);
    assign sample = tick && !restart && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || sample) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R7: two samples are always at least HALF ticks apart
    p_sample_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_enable,
    input  logic rx_disable,
    input  logic rx_reset_req,
    output logic rx_on,
    output logic reset_pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_on      <= 1'b0;
            reset_pend <= 1'b0;
        end else begin
            if (rx_disable) begin
                rx_on <= 1'b0;
            end else if (rx_enable) begin
                rx_on <= 1'b1;
            end
            reset_pend <= rx_reset_req;
        end
    end

    p_disable_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_disable |=> !rx_on);
    p_enable_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && !rx_disable) |=> rx_on);
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     baud_tick,
    input  logic                     rx_line,
    input  logic [FMT_W-1:0]         mode,
    input  logic                     rx_enable,
    input  logic                     rx_disable,
    input  logic                     rx_reset_req,
    output logic [MAX_DATA_BITS-1:0] char_data,
    output logic                     char_valid,
    output logic                     parity_err,
    output logic                     framing_err
);
    rx_state_t              state, next_state;
    rx_cfg_t                cfg_dec, cfg_q;
    logic                   rx_on, reset_pend, abort;
    logic                   sample, timer_restart;
    logic                   armed;
    logic [IDX_W-1:0]       bit_idx;
    logic [MAX_DATA_BITS-1:0] data_q;
    logic                   ones_odd, par_bad, stop_bad;
    logic                   last_data;

    uart_rx_mode_decode u_dec (.fmt(mode), .cfg(cfg_dec));

    uart_rx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_disable(rx_disable),
        .rx_reset_req(rx_reset_req), .rx_on(rx_on), .reset_pend(reset_pend)
    );

    assign abort         = reset_pend || !rx_on;
    assign timer_restart = (state == S_IDLE) || abort;

    uart_rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .restart(timer_restart),
        .half_sel(state == S_START), .sample(sample)
    );

    assign last_data = (bit_idx == IDX_W'(cfg_q.nbits - LEN_W'(1)));

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:   if (baud_tick && armed && !rx_line) next_state = S_START;
            S_START:  if (sample) next_state = rx_line ? S_IDLE : S_DATA;
            S_DATA:   if (sample && last_data)
                          next_state = (cfg_q.par == PAR_NONE) ? S_STOP1 : S_PARITY;
            S_PARITY: if (sample) next_state = S_STOP1;
            S_STOP1:  if (sample) next_state = cfg_q.two_stop ? S_STOP2 : S_IDLE;
            S_STOP2:  if (sample) next_state = S_IDLE;
            default:  next_state = S_IDLE;
        endcase
        if (abort) next_state = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            armed       <= 1'b0;
            bit_idx     <= '0;
            data_q      <= '0;
            ones_odd    <= 1'b0;
            par_bad     <= 1'b0;
            stop_bad    <= 1'b0;
            char_data   <= '0;
            char_valid  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
        end else begin
            char_valid  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            if (reset_pend) begin
                armed    <= 1'b0;
                bit_idx  <= '0;
                data_q   <= '0;
                ones_odd <= 1'b0;
                par_bad  <= 1'b0;
                stop_bad <= 1'b0;
            end else begin
                if (state == S_IDLE) begin
                    cfg_q <= cfg_dec;
                    if (baud_tick) armed <= rx_line;
                end else begin
                    armed <= 1'b0;
                end
                if (sample && !abort) begin
                    unique case (state)
                        S_START: begin
                            bit_idx  <= '0;
                            data_q   <= '0;
                            ones_odd <= 1'b0;
                            par_bad  <= 1'b0;
                            stop_bad <= 1'b0;
                        end
                        S_DATA: begin
                            data_q[bit_idx] <= rx_line;
                            ones_odd        <= ones_odd ^ rx_line;
                            bit_idx         <= bit_idx + IDX_W'(1);
                        end
                        S_PARITY: begin
                            par_bad <= (rx_line != par_expected(cfg_q.par, ones_odd));
                        end
                        S_STOP1: begin
                            stop_bad <= !rx_line;
                            if (!cfg_q.two_stop) begin
                                char_valid  <= 1'b1;
                                char_data   <= data_q;
                                parity_err  <= par_bad;
                                framing_err <= !rx_line;
                            end
                        end
                        S_STOP2: begin
                            char_valid  <= 1'b1;
                            char_data   <= data_q;
                            parity_err  <= par_bad;
                            framing_err <= stop_bad || !rx_line;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R11: strobe is one cycle, flags only alongside it
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
    p_flags_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err || framing_err) |-> char_valid);
    // R1: unused upper bits are zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && cfg_q.nbits == LEN_W'(6)) |-> (char_data[7:6] == 2'b00));
    p_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && cfg_q.nbits != LEN_W'(8)) |-> !char_data[7]);
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> (LEN_W'(bit_idx) < cfg_q.nbits));
    // R4: no parity state without parity
    p_no_parity_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PARITY) |-> (cfg_q.par != PAR_NONE));
    // R7: a high mid-bit sample of the start bit returns to idle
    p_glitch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && sample && rx_line) |=> (state == S_IDLE));
    // R8: receiver off forces idle
    p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> (state == S_IDLE));
    // R9: reset request clears the framer
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pend |=> (state == S_IDLE));
    // R10: format held during a character
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(cfg_q));
    // R6: no start without the line having been seen high
    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && next_state == S_START) |-> armed);
endmodule

// File: tb/uart_rx_framer_tb.sv
module uart_rx_framer_tb_top;
    localparam int OS       = 16;
    localparam int TICK_DIV = 2;
    localparam int BIT_CLKS = OS * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] mode = 8'h20;
    logic       rx_enable = 1'b0, rx_disable = 1'b0, rx_reset_req = 1'b0;
    logic [7:0] char_data;
    logic       char_valid, parity_err, framing_err;

    int n_cmp = 0, n_bad = 0;
    int cap_n = 0;
    logic [7:0] cap_d;
    logic       cap_p, cap_f;
    bit         done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

    uart_rx_framer #(.OVERSAMPLE(OS)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
        .mode(mode), .rx_enable(rx_enable), .rx_disable(rx_disable),
        .rx_reset_req(rx_reset_req), .char_data(char_data), .char_valid(char_valid),
        .parity_err(parity_err), .framing_err(framing_err)
    );

    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            cap_n = cap_n + 1;
            cap_d = char_data;
            cap_p = parity_err;
            cap_f = framing_err;
        end
    end

    function automatic int f_len(logic [7:0] m);
        case (m[2:1])
            2'b11:   return 6;
            2'b10:   return 7;
            default: return 8;
        endcase
    endfunction

    function automatic bit f_has_par(logic [7:0] m);
        return !m[5];
    endfunction

    function automatic bit f_two(logic [7:0] m);
        return m[7:6] == 2'b10;
    endfunction

    function automatic logic [7:0] f_mask(logic [7:0] d, logic [7:0] m);
        return d & ((9'h1 << f_len(m)) - 9'h1);
    endfunction

    function automatic logic f_pbit(logic [7:0] d, logic [7:0] m);
        logic [7:0] md;
        md = f_mask(d, m);
        case (m[4:3])
            2'b00:   return ^md;
            2'b01:   return ~^md;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(logic v);
        @(negedge clk) rx_line = v;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) rx_enable = 1'b1;
        if (which == 1) rx_disable = 1'b1;
        if (which == 2) rx_reset_req = 1'b1;
        if (which == 3) begin rx_enable = 1'b1; rx_disable = 1'b1; end
        @(negedge clk);
        rx_enable = 1'b0; rx_disable = 1'b0; rx_reset_req = 1'b0;
    endtask

    task automatic send_frame(logic [7:0] d, logic [7:0] m, bit bad_par, bit s1_low,
                              bit s2_low, bit swap, logic [7:0] m2, int hold_low);
        mode = m;
        drive_bit(1'b0);
        for (int i = 0; i < f_len(m); i++) begin
            drive_bit(d[i]);
            if (swap && i == 1) mode = m2;
        end
        if (f_has_par(m)) drive_bit(f_pbit(d, m) ^ bad_par);
        drive_bit(!s1_low);
        if (f_two(m)) drive_bit(!s2_low);
        for (int i = 0; i < hold_low; i++) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic frame_chk(string req, logic [7:0] d, logic [7:0] m, bit bad_par,
                             bit s1_low, bit s2_low, bit swap, logic [7:0] m2, int hold_low);
        int n0;
        n0 = cap_n;
        send_frame(d, m, bad_par, s1_low, s2_low, swap, m2, hold_low);
        chk({req, " count"}, cap_n - n0, 1);
        if (cap_n != n0) begin
            chk({req, " data R1"}, cap_d, f_mask(d, m));
            chk({req, " parity R2"}, cap_p, f_has_par(m) && bad_par);
            chk({req, " framing R5"}, cap_f, s1_low || (f_two(m) && s2_low));
        end
    endtask

    task automatic none_chk(string req, int n0);
        chk(req, cap_n - n0, 0);
    endtask

    initial begin
        int n0;
        void'($urandom(32'h1cab_0e57));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset valid", char_valid, 0);
        chk("R11 reset data", char_data, 0);
        chk("R11 reset flags", {parity_err, framing_err}, 0);

        // R8 receiver off after reset
        n0 = cap_n;
        send_frame(8'h5A, 8'h20, 0, 0, 0, 0, 8'h0, 0);
        none_chk("R8 off after reset", n0);
        // R8 disable wins when both pulsed
        pulse(3);
        n0 = cap_n;
        send_frame(8'h5A, 8'h20, 0, 0, 0, 0, 8'h0, 0);
        none_chk("R8 disable wins", n0);
        pulse(0);
        drive_bit(1'b1);
        frame_chk("R1 8N1", 8'hA5, 8'h20, 0, 0, 0, 0, 8'h0, 0);

        // R7 glitch rejected
        n0 = cap_n;
        @(negedge clk) rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        none_chk("R7 glitch", n0);
        frame_chk("R7 after glitch", 8'h3C, 8'h20, 0, 0, 0, 0, 8'h0, 0);

        // R2 even and odd parity
        frame_chk("R2 7E good", 8'h55, 8'h04, 0, 0, 0, 0, 8'h0, 0);
        frame_chk("R2 8O bad", 8'h81, 8'h08, 1, 0, 0, 0, 8'h0, 0);
        frame_chk("R2 8E bad", 8'h07, 8'h00, 1, 0, 0, 0, 8'h0, 0);
        // R3 space and mark
        frame_chk("R3 space good", 8'hF0, 8'h10, 0, 0, 0, 0, 8'h0, 0);
        frame_chk("R3 space bad", 8'hF0, 8'h10, 1, 0, 0, 0, 8'h0, 0);
        frame_chk("R3 mark good", 8'h0F, 8'h18, 0, 0, 0, 0, 8'h0, 0);
        frame_chk("R3 mark bad", 8'h0F, 8'h18, 1, 0, 0, 0, 8'h0, 0);
        // R4 no parity, R5 two stops with second low
        frame_chk("R4 none 2stop", 8'hC3, 8'hA0, 0, 0, 1, 0, 8'h0, 0);
        frame_chk("R5 two stop first low", 8'h99, 8'h80, 0, 1, 0, 0, 8'h0, 0);
        // R1 six bits upper zero
        frame_chk("R1 6bit", 8'hFF, 8'h26, 0, 0, 0, 0, 8'h0, 0);

        // R6 break held low for 10 extra bits
        n0 = cap_n;
        send_frame(8'h00, 8'h20, 0, 1, 0, 0, 8'h0, 10);
        chk("R6 break count", cap_n - n0, 1);
        chk("R6 break data", cap_d, 0);
        chk("R6 break framing", cap_f, 1);

        // R10 mode change mid-character ignored
        frame_chk("R10 mode swap", 8'h6B, 8'h0C, 1, 0, 0, 1, 8'hA0, 0);

        // R9 reset mid-character
        n0 = cap_n;
        mode = 8'h20;
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0);
        pulse(2);
        rx_line = 1'b1;
        repeat (14 * BIT_CLKS) @(negedge clk);
        none_chk("R9 partial dropped", n0);
        frame_chk("R9 after reset", 8'h42, 8'h20, 0, 0, 0, 0, 8'h0, 0);

        // R8 disable mid-character
        n0 = cap_n;
        drive_bit(1'b0); drive_bit(1'b0); drive_bit(1'b1);
        pulse(1);
        rx_line = 1'b1;
        repeat (14 * BIT_CLKS) @(negedge clk);
        none_chk("R8 disable mid-char", n0);
        pulse(0);
        drive_bit(1'b1);
        frame_chk("R8 re-enabled", 8'h18, 8'h20, 0, 0, 0, 0, 8'h0, 0);

        // random formats and data
        for (int k = 0; k < 120; k++) begin
            logic [7:0] m, d;
            bit bp, s1, s2;
            m = $urandom;
            m[7:6] = ($urandom % 2) ? 2'b10 : 2'b00;
            d = $urandom;
            bp = ($urandom % 5) == 0;
            s1 = ($urandom % 10) == 0;
            s2 = ($urandom % 10) == 0;
            frame_chk("R1-rand", d, m, bp, s1, s2, 0, 8'h0, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R11 actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule